// File: doc/BRIEF.md
# Delayed-Branch Next-PC Unit

This block holds the fetch address pair of a RISC core with one architectural delay slot. The pair is the address of the instruction now issuing and the address that follows it. On every retired instruction it computes the new pair from the decoded control-transfer kind. Conditional branches are resolved against the integer flags (negative, zero, overflow, carry) or against a floating-point compare result. Calls and register-indirect jump-and-link produce a link-register write that carries the address of the transfer itself.

The annul bit of a branch controls whether the delay-slot instruction is suppressed, and its effect depends on the branch. A conditional branch annuls its slot only when it is not taken. Branch-always with annul jumps and suppresses the slot. Branch-never with annul skips the slot entirely. The conditional trap instruction uses the same sixteen integer conditions and raises a combinational trap request. An instruction marked as annulled retires as a no-op and produces neither a link write nor a trap.

Top module: `dlyslot_npc_unit`

## Requirements
- R1: While rst_n is low and after its release, pc_o equals RESET_PC, npc_o equals RESET_PC+4, and annul_o, link_we_o and trap_req_o are 0.
- R2: In a cycle with step_i low, pc_o, npc_o and annul_o keep their values at the next edge.
- R3: For an integer branch (xfer_i=1), with icc_i={N,Z,V,C}, the condition is taken as follows. Codes 0..7 mean false, Z, Z|(N^V), N^V, C|Z, C, N and V. Codes 8..15 are the complements of codes 0..7, so code 8 is always true.
- R4: For a floating-point branch (xfer_i=2), fcc_i encodes 0=equal, 1=less, 2=greater and 3=unordered. Codes 0..7 are true for none, {L,G,U}, {L,G}, {L,U}, {L}, {G,U}, {G} and {U}. Codes 8..15 are the complements of codes 0..7.
- R5: A taken branch sets pc_o to the old npc_o and npc_o to pc_o + (sign-extended disp22_i shifted left by 2), modulo 2^ADDR_W.
- R6: A not-taken branch with code other than 0 sets pc_o to the old npc_o and npc_o to the old npc_o+4. annul_o becomes equal to annul_i.
- R7: Branch-always (code 8) with annul_i=1 is taken and sets annul_o to 1. A taken branch with any code other than 8 leaves annul_o at 0, whatever annul_i is.
- R8: Branch-never (code 0) with annul_i=1 sets pc_o to the old npc_o+4, npc_o to the old npc_o+8 and annul_o to 0. With annul_i=0 it behaves as in R6.
- R9: A call (xfer_i=3) asserts link_we_o with link_idx_o=LINK_REG (15) and link_val_o=pc_o during the step. It then sets npc_o to pc_o + (disp30_i shifted left by 2), modulo 2^ADDR_W.
- R10: A jump-and-link (xfer_i=4) asserts link_we_o with link_idx_o=rd_i and link_val_o=pc_o during the step, and sets npc_o to jmp_tgt_i.
- R11: A conditional trap (xfer_i=5) asserts trap_req_o during the step exactly when its cond_i is true under the R3 rules. It updates the pair sequentially.
- R12: A step taken while annul_o=1 asserts neither link_we_o nor trap_req_o for any xfer_i. It sets pc_o to the old npc_o, npc_o to the old npc_o+4 and annul_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | The instruction at pc_o retires this cycle |
| xfer_i | input | 3 | Transfer kind: 0 none, 1 integer branch, 2 float branch, 3 call, 4 jump-and-link, 5 conditional trap |
| cond_i | input | 4 | Condition code of a branch or trap |
| annul_i | input | 1 | Annul bit of a branch |
| disp22_i | input | 22 | Signed word displacement of a branch |
| disp30_i | input | 30 | Word displacement of a call |
| jmp_tgt_i | input | ADDR_W | Computed target of a jump-and-link |
| rd_i | input | REG_IDX_W | Destination register of a jump-and-link |
| icc_i | input | 4 | Integer flags {N,Z,V,C} |
| fcc_i | input | 2 | Floating-point compare result |
| pc_o | output | ADDR_W | Address of the instruction now issuing |
| npc_o | output | ADDR_W | Address that follows it |
| annul_o | output | 1 | The instruction at pc_o is annulled |
| link_we_o | output | 1 | Link-register write strobe |
| link_idx_o | output | REG_IDX_W | Link-register index |
| link_val_o | output | ADDR_W | Link value (address of the transfer) |
| trap_req_o | output | 1 | Conditional trap request |

## Verification
The bench builds the unit with ADDR_W=16 and RESET_PC=16'hFFF0. With addresses that narrow, modular wrap of sequential steps, branch targets and call targets occurs within a few hundred steps, including wrap right after reset. Every condition code is swept against every integer flag pattern and every float compare result, with the annul bit both clear and set. Each branch is followed by a call or a trap-always, so that the suppression of annulled slots is observed at the link and trap outputs.

// File: rtl/dsn_pkg.sv
`timescale 1ns/1ps
package dsn_pkg;
   typedef enum logic [2:0] {
      XF_SEQ  = 3'd0,
      XF_IBR  = 3'd1,
      XF_FBR  = 3'd2,
      XF_CALL = 3'd3,
      XF_JMPL = 3'd4,
      XF_TRAP = 3'd5
   } xfer_e;

   localparam int          COND_W      = 4;
   localparam int          COND_N      = 1 << COND_W;
   localparam int          COND_HALF   = COND_N / 2;
   localparam logic [3:0]  COND_NEVER  = 4'd0;
   localparam logic [3:0]  COND_ALWAYS = 4'd8;
endpackage

// File: rtl/dsn_cond_eval.sv
`timescale 1ns/1ps
module dsn_cond_eval
   import dsn_pkg::*;
(
   input  logic [COND_W-1:0] cond_i,
   input  logic [3:0]        icc_i,
   input  logic [1:0]        fcc_i,
   output logic              int_true_o,
   output logic              flt_true_o
);
   logic fl_n, fl_z, fl_v, fl_c;
   logic fc_e, fc_l, fc_g, fc_u;
   logic [COND_HALF-1:0] int_base, flt_base;
   logic [COND_N-1:0]    int_tbl, flt_tbl;

   assign {fl_n, fl_z, fl_v, fl_c} = icc_i;
   assign fc_e = (fcc_i == 2'd0);
   assign fc_l = (fcc_i == 2'd1);
   assign fc_g = (fcc_i == 2'd2);
   assign fc_u = (fcc_i == 2'd3);

   assign int_base = {fl_v, fl_n, fl_c, fl_c | fl_z, fl_n ^ fl_v,
                      fl_z | (fl_n ^ fl_v), fl_z, 1'b0};
   assign flt_base = {fc_u, fc_g, fc_g | fc_u, fc_l, fc_l | fc_u,
                      fc_l | fc_g, fc_l | fc_g | fc_u, 1'b0};

   // upper half of the code space is the complement of the lower half
   for (genvar g = 0; g < COND_N; g++) begin : g_code
      if (g < COND_HALF) begin : g_lo
         assign int_tbl[g] = int_base[g];
         assign flt_tbl[g] = flt_base[g];
      end else begin : g_hi
         assign int_tbl[g] = ~int_base[g-COND_HALF];
         assign flt_tbl[g] = ~flt_base[g-COND_HALF];
      end
   end

   assign int_true_o = int_tbl[cond_i];
   assign flt_true_o = flt_tbl[cond_i];
endmodule

// File: rtl/dsn_target_gen.sv
`timescale 1ns/1ps
module dsn_target_gen #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [ADDR_W-1:0] npc_i,
   input  logic [21:0]       disp22_i,
   input  logic [29:0]       disp30_i,
   output logic [ADDR_W-1:0] br_tgt_o,
   output logic [ADDR_W-1:0] call_tgt_o,
   output logic [ADDR_W-1:0] seq_o,
   output logic [ADDR_W-1:0] skip_o
);
   localparam logic [ADDR_W-1:0] WORD  = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] DWORD = ADDR_W'(8);

   if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_w
      $error("dsn_target_gen: ADDR_W must lie in 8..64");
   end

   assign br_tgt_o   = pc_i + ADDR_W'($signed({disp22_i, 2'b00}));
   assign call_tgt_o = pc_i + ADDR_W'({disp30_i, 2'b00});
   assign seq_o      = npc_i + WORD;
   assign skip_o     = npc_i + DWORD;
endmodule

// File: rtl/dsn_npc_seq.sv
`timescale 1ns/1ps
module dsn_npc_seq
   import dsn_pkg::*;
#(
   parameter int                 ADDR_W   = 32,
   parameter logic [ADDR_W-1:0]  RESET_PC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  xfer_e             xfer_i,
   input  logic [COND_W-1:0] cond_i,
   input  logic              annul_i,
   input  logic              int_true_i,
   input  logic              flt_true_i,
   input  logic [ADDR_W-1:0] br_tgt_i,
   input  logic [ADDR_W-1:0] call_tgt_i,
   input  logic [ADDR_W-1:0] jmp_tgt_i,
   input  logic [ADDR_W-1:0] seq_i,
   input  logic [ADDR_W-1:0] skip_i,
   output logic [ADDR_W-1:0] pc_o,
   output logic [ADDR_W-1:0] npc_o,
   output logic              annul_o
);
   localparam logic [ADDR_W-1:0] RESET_NPC = RESET_PC + ADDR_W'(4);

   logic [ADDR_W-1:0] pc_q, npc_q, pc_d, npc_d;
   logic              ann_q, ann_d;
   logic              br_true;

   assign br_true = (xfer_i == XF_IBR) ? int_true_i : flt_true_i;

   always_comb begin
      pc_d  = pc_q;
      npc_d = npc_q;
      ann_d = ann_q;
      if (step_i) begin
         pc_d  = npc_q;
         npc_d = seq_i;
         ann_d = 1'b0;
         if (!ann_q) begin
            case (xfer_i)
               XF_IBR, XF_FBR: begin
                  if (annul_i && cond_i == COND_NEVER) begin
                     pc_d  = seq_i;
                     npc_d = skip_i;
                  end else if (br_true) begin
                     npc_d = br_tgt_i;
                     ann_d = annul_i && (cond_i == COND_ALWAYS);
                  end else begin
                     ann_d = annul_i;
                  end
               end
               XF_CALL: npc_d = call_tgt_i;
               XF_JMPL: npc_d = jmp_tgt_i;
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q  <= RESET_PC;
         npc_q <= RESET_NPC;
         ann_q <= 1'b0;
      end else begin
         pc_q  <= pc_d;
         npc_q <= npc_d;
         ann_q <= ann_d;
      end
   end

   assign pc_o    = pc_q;
   assign npc_o   = npc_q;
   assign annul_o = ann_q;
endmodule

// File: rtl/dlyslot_npc_unit.sv
`timescale 1ns/1ps
module dlyslot_npc_unit
   import dsn_pkg::*;
#(
   parameter int                 ADDR_W    = 32,
   parameter int                 REG_IDX_W = 5,
   parameter int                 LINK_REG  = 15,
   parameter logic [ADDR_W-1:0]  RESET_PC  = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 step_i,
   input  logic [2:0]           xfer_i,
   input  logic [3:0]           cond_i,
   input  logic                 annul_i,
   input  logic [21:0]          disp22_i,
   input  logic [29:0]          disp30_i,
   input  logic [ADDR_W-1:0]    jmp_tgt_i,
   input  logic [REG_IDX_W-1:0] rd_i,
   input  logic [3:0]           icc_i,
   input  logic [1:0]           fcc_i,
   output logic [ADDR_W-1:0]    pc_o,
   output logic [ADDR_W-1:0]    npc_o,
   output logic                 annul_o,
   output logic                 link_we_o,
   output logic [REG_IDX_W-1:0] link_idx_o,
   output logic [ADDR_W-1:0]    link_val_o,
   output logic                 trap_req_o
);
   localparam logic [REG_IDX_W-1:0] LINK_IDX = REG_IDX_W'(LINK_REG);

   if (LINK_REG < 0 || LINK_REG >= (1 << REG_IDX_W)) begin : g_bad_link
      $error("dlyslot_npc_unit: LINK_REG does not fit REG_IDX_W");
   end

   xfer_e             xfer;
   logic              int_true, flt_true, live;
   logic [ADDR_W-1:0] br_tgt, call_tgt, seq_nxt, skip_nxt;

   assign xfer = xfer_e'(xfer_i);
   assign live = step_i && !annul_o;

   dsn_cond_eval u_cond (
      .cond_i     (cond_i),
      .icc_i      (icc_i),
      .fcc_i      (fcc_i),
      .int_true_o (int_true),
      .flt_true_o (flt_true)
   );

   dsn_target_gen #(.ADDR_W(ADDR_W)) u_tgt (
      .pc_i       (pc_o),
      .npc_i      (npc_o),
      .disp22_i   (disp22_i),
      .disp30_i   (disp30_i),
      .br_tgt_o   (br_tgt),
      .call_tgt_o (call_tgt),
      .seq_o      (seq_nxt),
      .skip_o     (skip_nxt)
   );

   dsn_npc_seq #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_i     (step_i),
      .xfer_i     (xfer),
      .cond_i     (cond_i),
      .annul_i    (annul_i),
      .int_true_i (int_true),
      .flt_true_i (flt_true),
      .br_tgt_i   (br_tgt),
      .call_tgt_i (call_tgt),
      .jmp_tgt_i  (jmp_tgt_i),
      .seq_i      (seq_nxt),
      .skip_i     (skip_nxt),
      .pc_o       (pc_o),
      .npc_o      (npc_o),
      .annul_o    (annul_o)
   );

   assign link_we_o  = live && (xfer == XF_CALL || xfer == XF_JMPL);
   assign link_idx_o = (xfer == XF_CALL) ? LINK_IDX : rd_i;
   assign link_val_o = pc_o;
   assign trap_req_o = live && (xfer == XF_TRAP) && int_true;
endmodule

// File: rtl/dsn_npc_chk.sv
`timescale 1ns/1ps
module dsn_npc_chk #(
   parameter int ADDR_W    = 32,
   parameter int REG_IDX_W = 5,
   parameter int LINK_REG  = 15
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 step_i,
   input logic [2:0]           xfer_i,
   input logic [ADDR_W-1:0]    pc_o,
   input logic [ADDR_W-1:0]    npc_o,
   input logic                 annul_o,
   input logic                 link_we_o,
   input logic [REG_IDX_W-1:0] link_idx_o,
   input logic [ADDR_W-1:0]    link_val_o,
   input logic                 trap_req_o
);
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> ($stable(pc_o) && $stable(npc_o) && $stable(annul_o))); // R2

   AST_PC_TAKES_NPC: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && xfer_i != 3'd1 && xfer_i != 3'd2) |=> pc_o == $past(npc_o)); // R5

   AST_CALL_LINK: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !annul_o && xfer_i == 3'd3) |->
         (link_we_o && link_idx_o == REG_IDX_W'(LINK_REG) && link_val_o == pc_o)); // R9

   AST_TRAP_ONLY_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req_o |-> (step_i && xfer_i == 3'd5)); // R11

   AST_ANNUL_NO_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
      annul_o |-> (!link_we_o && !trap_req_o)); // R12

   AST_ANNUL_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && annul_o) |=> !annul_o); // R12

   AST_ANNUL_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && annul_o) |=>
         (pc_o == $past(npc_o) && npc_o == $past(npc_o) + ADDR_W'(4))); // R12

   AST_SIDE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({link_we_o, trap_req_o})); // R11
endmodule

bind dlyslot_npc_unit dsn_npc_chk #(
   .ADDR_W(ADDR_W), .REG_IDX_W(REG_IDX_W), .LINK_REG(LINK_REG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .step_i     (step_i),
   .xfer_i     (xfer_i),
   .pc_o       (pc_o),
   .npc_o      (npc_o),
   .annul_o    (annul_o),
   .link_we_o  (link_we_o),
   .link_idx_o (link_idx_o),
   .link_val_o (link_val_o),
   .trap_req_o (trap_req_o)
);

// File: tb/dlyslot_npc_unit_tb_top.sv
`timescale 1ns/1ps
module dlyslot_npc_unit_tb_top;
   localparam int          AW    = 16;
   localparam logic [15:0] RSTPC = 16'hFFF0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_i = 1'b0;
   logic [2:0]  xfer_i = '0;
   logic [3:0]  cond_i = '0;
   logic        annul_i = 1'b0;
   logic [21:0] disp22_i = '0;
   logic [29:0] disp30_i = '0;
   logic [15:0] jmp_tgt_i = '0;
   logic [4:0]  rd_i = '0;
   logic [3:0]  icc_i = '0;
   logic [1:0]  fcc_i = '0;
   logic [15:0] pc_o, npc_o, link_val_o;
   logic        annul_o, link_we_o, trap_req_o;
   logic [4:0]  link_idx_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   logic [15:0] mpc, mnpc;
   logic        mann;

   always #4 clk = ~clk;

   dlyslot_npc_unit #(
      .ADDR_W(AW), .REG_IDX_W(5), .LINK_REG(15), .RESET_PC(RSTPC)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .step_i(step_i), .xfer_i(xfer_i),
      .cond_i(cond_i), .annul_i(annul_i), .disp22_i(disp22_i),
      .disp30_i(disp30_i), .jmp_tgt_i(jmp_tgt_i), .rd_i(rd_i),
      .icc_i(icc_i), .fcc_i(fcc_i), .pc_o(pc_o), .npc_o(npc_o),
      .annul_o(annul_o), .link_we_o(link_we_o), .link_idx_o(link_idx_o),
      .link_val_o(link_val_o), .trap_req_o(trap_req_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic bit ref_int(input logic [3:0] c, input logic [3:0] f);
      bit n, z, v, cy;
      n = f[3]; z = f[2]; v = f[1]; cy = f[0];
      case (c)
         4'd0:  return 0;
         4'd1:  return z;
         4'd2:  return z | (n ^ v);
         4'd3:  return n ^ v;
         4'd4:  return cy | z;
         4'd5:  return cy;
         4'd6:  return n;
         4'd7:  return v;
         4'd8:  return 1;
         4'd9:  return !z;
         4'd10: return !(z | (n ^ v));
         4'd11: return !(n ^ v);
         4'd12: return !(cy | z);
         4'd13: return !cy;
         4'd14: return !n;
         default: return !v;
      endcase
   endfunction

   function automatic bit ref_flt(input logic [3:0] c, input logic [1:0] r);
      bit e, l, g, u;
      e = (r == 0); l = (r == 1); g = (r == 2); u = (r == 3);
      case (c)
         4'd0:  return 0;
         4'd1:  return l | g | u;
         4'd2:  return l | g;
         4'd3:  return u | l;
         4'd4:  return l;
         4'd5:  return u | g;
         4'd6:  return g;
         4'd7:  return u;
         4'd8:  return 1;
         4'd9:  return e;
         4'd10: return e | u;
         4'd11: return g | e;
         4'd12: return u | g | e;
         4'd13: return l | e;
         4'd14: return u | l | e;
         default: return e | l | g;
      endcase
   endfunction

   function automatic logic [15:0] br_target(input logic [15:0] p, input logic [21:0] d);
      int off;
      off = d[21] ? (int'(d) - 4194304) * 4 : int'(d) * 4;
      return 16'(int'(p) + off);
   endfunction

   task automatic do_step(input logic [2:0] xt, input logic [3:0] cd, input logic ab,
                          input logic [21:0] d22, input logic [29:0] d30,
                          input logic [15:0] jt, input logic [4:0] rd,
                          input logic [3:0] ic, input logic [1:0] fc, input string grp);
      logic [15:0] epc, enpc;
      logic        eann, ewe, etrap;
      logic [4:0]  eidx;
      bit          t;
      string       rtag, stag;
      @(negedge clk);
      xfer_i = xt; cond_i = cd; annul_i = ab; disp22_i = d22; disp30_i = d30;
      jmp_tgt_i = jt; rd_i = rd; icc_i = ic; fcc_i = fc; step_i = 1'b1;
      #1;
      ewe = 0; etrap = 0; eidx = 0;
      epc = mnpc; enpc = mnpc + 16'd4; eann = 0;
      rtag = "R12"; stag = "R12";
      if (!mann) begin
         rtag = "R6"; stag = "R11";
         case (xt)
            3'd1, 3'd2: begin
               t = (xt == 3'd1) ? ref_int(cd, ic) : ref_flt(cd, fc);
               if (ab && cd == 4'd0) begin
                  epc = mnpc + 16'd4; enpc = mnpc + 16'd8; rtag = "R8";
               end else if (t) begin
                  enpc = br_target(mpc, d22);
                  eann = ab && (cd == 4'd8);
                  rtag = ab ? "R7" : "R5";
               end else begin
                  eann = ab; rtag = "R6";
               end
            end
            3'd3: begin
               ewe = 1; eidx = 5'd15; stag = "R9"; rtag = "R9";
               enpc = 16'(32'(mpc) + {d30, 2'b00});
            end
            3'd4: begin
               ewe = 1; eidx = rd; enpc = jt; stag = "R10"; rtag = "R10";
            end
            3'd5: begin
               etrap = ref_int(cd, ic); rtag = "R11";
            end
            default: ;
         endcase
      end
      chk({grp, " ", stag, " trap_req"}, 32'(trap_req_o), 32'(etrap));
      chk({grp, " ", stag, " link_we"}, 32'(link_we_o), 32'(ewe));
      if (ewe) begin
         chk({grp, " ", stag, " link_idx"}, 32'(link_idx_o), 32'(eidx));
         chk({grp, " ", stag, " link_val"}, 32'(link_val_o), 32'(mpc));
      end
      @(posedge clk);
      #1;
      step_i = 1'b0;
      chk({grp, " ", rtag, " pc"}, 32'(pc_o), 32'(epc));
      chk({grp, " ", rtag, " npc"}, 32'(npc_o), 32'(enpc));
      chk({grp, " ", rtag, " annul"}, 32'(annul_o), 32'(eann));
      mpc = epc; mnpc = enpc; mann = eann;
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 pc in reset", 32'(pc_o), 32'(RSTPC));
      chk("R1 npc in reset", 32'(npc_o), 32'(RSTPC + 16'd4));
      chk("R1 annul in reset", 32'(annul_o), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk("R1 pc after reset", 32'(pc_o), 32'(RSTPC));
      chk("R1 npc after reset", 32'(npc_o), 32'(RSTPC + 16'd4));
      chk("R1 link_we after reset", 32'(link_we_o), 0);
      chk("R1 trap after reset", 32'(trap_req_o), 0);
      mpc = RSTPC; mnpc = RSTPC + 16'd4; mann = 1'b0;

      // R2: idle cycles with busy inputs leave the pair untouched
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         xfer_i = 3'(k % 6); cond_i = 4'd8; annul_i = 1'b1;
         disp22_i = 22'h3FFFF0; disp30_i = 30'h40; jmp_tgt_i = 16'h1234;
         @(posedge clk);
         #1;
         chk("R2 pc hold", 32'(pc_o), 32'(mpc));
         chk("R2 npc hold", 32'(npc_o), 32'(mnpc));
         chk("R2 annul hold", 32'(annul_o), 0);
      end

      // R3 with R5..R8 and R11/R12 follow-ups
      for (int c = 0; c < 16; c++)
         for (int f = 0; f < 16; f++)
            for (int a = 0; a < 2; a++) begin
               logic [21:0] d;
               d = 22'((c * 16 + f) * 37 + 3) ^ (((c + f) % 2 == 1) ? 22'h3FFF00 : 22'h0);
               do_step(3'd1, 4'(c), 1'(a), d, '0, '0, '0, 4'(f), '0, "R3");
               if (a == 1) do_step(3'd5, 4'd8, 1'b0, '0, '0, '0, '0, 4'(f), '0, "R3");
               else        do_step(3'd3, 4'd0, 1'b0, '0, 30'(c * 5 + 1), '0, '0, '0, '0, "R3");
            end

      // R4 float branches
      for (int c = 0; c < 16; c++)
         for (int r = 0; r < 4; r++)
            for (int a = 0; a < 2; a++) begin
               logic [21:0] d;
               d = 22'(c * 97 + r * 11) ^ ((r % 2 == 1) ? 22'h3FF000 : 22'h0);
               do_step(3'd2, 4'(c), 1'(a), d, '0, '0, '0, 4'hF, 2'(r), "R4");
               if (r % 2 == 0) do_step(3'd3, 4'd0, 1'b0, '0, 30'(r * 9 + c), '0, '0, '0, '0, "R4");
               else            do_step(3'd5, 4'd8, 1'b0, '0, '0, '0, '0, 4'h0, '0, "R4");
            end

      // R9 calls across the wrap
      for (int k = 0; k < 40; k++)
         do_step(3'd3, 4'd0, 1'b0, '0, 30'(k * 613) ^ ((k % 3 == 0) ? 30'h3FFFC000 : 30'h0),
                 '0, '0, '0, '0, "R9");

      // R10 jump-and-link to every destination register
      for (int k = 0; k < 32; k++)
         do_step(3'd4, 4'd0, 1'b0, '0, '0, 16'(k * 2131 + 4), 5'(k), '0, '0, "R10");

      // R11 conditional traps over all codes and flags
      for (int c = 0; c < 16; c++)
         for (int f = 0; f < 16; f++)
            do_step(3'd5, 4'(c), 1'b0, '0, '0, '0, '0, 4'(f), '0, "R11");

      // R12 annulled slot holding a jump-and-link and an annulling branch
      for (int k = 0; k < 8; k++) begin
         do_step(3'd1, 4'd8, 1'b1, 22'(k * 5 + 2), '0, '0, '0, '0, '0, "R7");
         if (k % 2 == 0) do_step(3'd4, 4'd0, 1'b0, '0, '0, 16'h2222, 5'd3, '0, '0, "R12");
         else            do_step(3'd1, 4'd8, 1'b1, 22'h3FFFFF, '0, '0, '0, '0, '0, "R12");
      end

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule